// File: doc/BRIEF.md
# I2C Register-Access Sequencer

This block carries out one complete register write or register read on a 7-bit I2C target. It does the work by driving the word-wide register interface of a byte-level I2C controller. A request names the direction, the target address, an 8-bit register index and a byte count from 1 to 16. Write payload arrives on a valid/ready byte stream. Read payload leaves on a second valid/ready byte stream. The end of every request is marked by a one-cycle `done` pulse, with `err` raised alongside it when the request failed.

Each accepted request starts by putting the controller through a timed reset: disable, then unit reset, then enable. The delays are counted in microseconds, using a tick derived from the system clock frequency parameter. Every byte is launched by a read-modify-write of the controller's control word. The sequencer then polls the controller's busy bit once per microsecond, with a fixed poll limit. Reads use a repeated start. A poll limit that runs out aborts the request at once.

Top module: `i2c_regseq`

## Requirements
- R1: After a valid request, three control-word writes come before any byte launch, in this order: 0x0000, then 0x0400 (bit 10, unit reset), then 0x6000 (bit 14 unit enable, bit 13 clock enable). Each of these writes follows the previous one by at least RESET_US microseconds.
- R2: A write request launches len+2 bytes, in this order: {addr,0} with flags 001, then the register index with flags 000, then the len stream bytes in the order received. Every stream byte carries flags 000 except the last, which carries 010 (stop). Flags are control bits [2:0]: bit 0 start, bit 1 stop, bit 2 NAK.
- R3: A read request launches len+3 bytes, in this order: {addr,0} with flags 001, the register index with 000, then {addr,1} with 001 (repeated start). It then launches len receive commands. These carry flags 000, except the final one, which carries 110 (NAK and stop).
- R4: Each launch is a control-word read followed at once by a control-word write. The write sets bit 3 (transfer) and replaces bits [2:0] with the flags. All other bits are copied from the value just read.
- R5: For a transmitted byte, the data register (bus_sel=1) is written with the byte before the launch. For a received byte, the data register is read only after the busy bit has read 0. Its value is then offered on rd_data, held stable until rd_ready, and bytes come out in bus order.
- R6: After a launch, the control word is polled about once per microsecond. If bit 3 reads 0 on any poll up to and including poll number POLL_LIMIT (1000), the request carries on.
- R7: If bit 3 still reads 1 on poll POLL_LIMIT, the request ends with done and err high. No further bus access is made.
- R8: A request with len 0 or len greater than MAX_LEN is answered with done and err on the cycle after acceptance, with no bus access.
- R9: done is a single-cycle pulse. err is low on a request that completes normally. req_ready is high only while idle.
- R10: A request with len equal to MAX_LEN (16) completes normally in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_rd | input | 1 | 1 = register read, 0 = register write |
| req_addr | input | 7 | Target address |
| req_reg | input | 8 | Register index |
| req_len | input | 5 | Payload byte count |
| wd_valid | input | 1 | Write payload byte offered |
| wd_ready | output | 1 | Write payload byte taken |
| wd_data | input | 8 | Write payload byte |
| rd_valid | output | 1 | Read payload byte offered |
| rd_ready | input | 1 | Read payload byte taken |
| rd_data | output | 8 | Read payload byte |
| done | output | 1 | End-of-request pulse |
| err | output | 1 | Failure flag, valid with done |
| bus_we | output | 1 | Controller register write strobe |
| bus_re | output | 1 | Controller register read strobe |
| bus_sel | output | 1 | 0 = control word, 1 = data register |
| bus_wdata | output | 32 | Controller write data |
| bus_rdata | input | 32 | Controller read data, same cycle as bus_re |

## Verification
Two events can land in the same cycle: the busy bit clearing, and the poll counter reaching its limit. The bench provokes this with its controller model, which reports busy for exactly 999 polls in one run and exactly 1000 polls in another, on the address byte of a one-byte write. The first run must finish with err low and all three bytes launched. The second must end with err high after a single launch, with the bus silent afterwards.

// File: rtl/i2c_regseq.sv
module i2c_regseq #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int RESET_US   = 10,
  parameter int POLL_LIMIT = 1000,
  parameter int MAX_LEN    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_rd,
  input  logic [6:0]  req_addr,
  input  logic [7:0]  req_reg,
  input  logic [$clog2(MAX_LEN+1)-1:0] req_len,
  input  logic        wd_valid,
  output logic        wd_ready,
  input  logic [7:0]  wd_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [7:0]  rd_data,
  output logic        done,
  output logic        err,
  output logic        bus_we,
  output logic        bus_re,
  output logic        bus_sel,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata
);
  localparam int DIV = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PW  = $clog2(DIV + 1);
  localparam int LW  = $clog2(MAX_LEN + 1);
  localparam int SW  = $clog2(MAX_LEN + 4);
  localparam int TW  = $clog2(RESET_US + 1);
  localparam int CW  = $clog2(POLL_LIMIT + 1);

  localparam logic [31:0] F_START = 32'h0001;
  localparam logic [31:0] F_STOP  = 32'h0002;
  localparam logic [31:0] F_NAK   = 32'h0004;
  localparam logic [31:0] F_XFER  = 32'h0008;
  localparam logic [31:0] F_URST  = 32'h0400;
  localparam logic [31:0] F_SCLEN = 32'h2000;
  localparam logic [31:0] F_UEN   = 32'h4000;

  typedef enum logic [3:0] {
    S_IDLE, S_RST0, S_W0, S_RST1, S_W1, S_EN, S_NEXT, S_GETD,
    S_DWR, S_CRD, S_CWR, S_POLL, S_PWT, S_RXRD, S_RXOUT, S_DONE
  } st_t;

  st_t           st;
  logic          rd_q, err_q;
  logic [6:0]    addr_q;
  logic [7:0]    reg_q, byte_q, rx_q;
  logic [LW-1:0] len_q;
  logic [SW-1:0] step, last;
  logic [31:0]   ctl_q, flg;
  logic [PW-1:0] pre;
  logic [TW-1:0] tmr;
  logic [CW-1:0] pcnt;
  logic [7:0]    txb;

  wire waiting = (st == S_W0) || (st == S_W1) || (st == S_PWT);
  wire tick    = waiting && (pre == PW'(DIV - 1));
  wire bad_len = (req_len == '0) || (req_len > LW'(MAX_LEN));
  wire is_rx   = rd_q && (step >= SW'(3));
  wire need_wd = !rd_q && (step >= SW'(2));

  assign last = rd_q ? SW'(len_q) + SW'(2) : SW'(len_q) + SW'(1);
  assign txb  = (step == '0) ? {addr_q, 1'b0} :
                (step == SW'(1)) ? reg_q : {addr_q, 1'b1};

  always_comb begin
    flg = '0;
    if (step == '0 || (rd_q && step == SW'(2))) flg = F_START;
    else if (step == last) flg = rd_q ? (F_NAK | F_STOP) : F_STOP;
  end

  assign req_ready = (st == S_IDLE);
  assign wd_ready  = (st == S_GETD);
  assign rd_valid  = (st == S_RXOUT);
  assign rd_data   = rx_q;
  assign done      = (st == S_DONE);
  assign err       = done && err_q;

  always_comb begin
    bus_we = 1'b0; bus_re = 1'b0; bus_sel = 1'b0; bus_wdata = '0;
    case (st)
      S_RST0:  bus_we = 1'b1;
      S_RST1:  begin bus_we = 1'b1; bus_wdata = F_URST; end
      S_EN:    begin bus_we = 1'b1; bus_wdata = F_UEN | F_SCLEN; end
      S_DWR:   begin bus_we = 1'b1; bus_sel = 1'b1; bus_wdata = {24'h0, byte_q}; end
      S_CRD, S_POLL: bus_re = 1'b1;
      S_CWR:   begin
        bus_we = 1'b1;
        bus_wdata = (ctl_q & ~(F_START | F_STOP | F_NAK)) | flg | F_XFER;
      end
      S_RXRD:  begin bus_re = 1'b1; bus_sel = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rd_q <= 1'b0; err_q <= 1'b0; addr_q <= '0; reg_q <= '0;
      len_q <= '0; step <= '0; byte_q <= '0; rx_q <= '0; ctl_q <= '0;
      pre <= '0; tmr <= '0; pcnt <= '0;
    end else begin
      pre <= (waiting && !tick) ? pre + 1'b1 : '0;
      case (st)
        S_IDLE: if (req_valid) begin
          rd_q <= req_rd; addr_q <= req_addr; reg_q <= req_reg; len_q <= req_len;
          step <= '0; tmr <= '0; err_q <= bad_len;
          st <= bad_len ? S_DONE : S_RST0;
        end
        S_RST0: st <= S_W0;
        S_W0: if (tick) begin
          if (tmr == TW'(RESET_US - 1)) begin tmr <= '0; st <= S_RST1; end
          else tmr <= tmr + 1'b1;
        end
        S_RST1: st <= S_W1;
        S_W1: if (tick) begin
          if (tmr == TW'(RESET_US - 1)) begin tmr <= '0; st <= S_EN; end
          else tmr <= tmr + 1'b1;
        end
        S_EN: st <= S_NEXT;
        S_NEXT: begin
          if (step > last) st <= S_DONE;
          else if (is_rx) st <= S_CRD;
          else if (need_wd) st <= S_GETD;
          else begin byte_q <= txb; st <= S_DWR; end
        end
        S_GETD: if (wd_valid) begin byte_q <= wd_data; st <= S_DWR; end
        S_DWR: st <= S_CRD;
        S_CRD: begin ctl_q <= bus_rdata; st <= S_CWR; end
        S_CWR: begin pcnt <= '0; st <= S_POLL; end
        S_POLL: begin
          if (!bus_rdata[3]) begin
            if (is_rx) st <= S_RXRD;
            else begin step <= step + 1'b1; st <= S_NEXT; end
          end else if (pcnt == CW'(POLL_LIMIT - 1)) begin
            err_q <= 1'b1; st <= S_DONE;
          end else begin
            pcnt <= pcnt + 1'b1; st <= S_PWT;
          end
        end
        S_PWT: if (tick) st <= S_POLL;
        S_RXRD: begin rx_q <= bus_rdata[7:0]; st <= S_RXOUT; end
        S_RXOUT: if (rd_ready) begin step <= step + 1'b1; st <= S_NEXT; end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> (done && err && !bus_we && !bus_re));

  // R4
  launch_rmw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_sel && bus_wdata[3]) |->
      ($past(bus_re && !bus_sel) && bus_wdata[31:4] == $past(bus_rdata[31:4])));

  // R1
  launch_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_sel && bus_wdata[3]) |-> (bus_wdata[14:13] == 2'b11));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/sim_i2c_regseq.sv
module sim_i2c_regseq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_rd = 0, wd_valid = 0, rd_ready = 0;
  logic [6:0] req_addr = 0;
  logic [7:0] req_reg = 0, wd_data = 0;
  logic [4:0] req_len = 0;
  logic req_ready, wd_ready, rd_valid, done, err, bus_we, bus_re, bus_sel;
  logic [7:0] rd_data;
  logic [31:0] bus_wdata, bus_rdata;

  i2c_regseq u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_addr(req_addr), .req_reg(req_reg), .req_len(req_len),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .err(err), .bus_we(bus_we), .bus_re(bus_re), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // controller model
  logic [31:0] m_ctl = 0;
  logic [7:0]  m_dat = 0;
  logic m_tb = 0, m_rx = 0, rdmode = 0;
  int m_left = 0, rxk = 0, n_l = 0, n_r = 0, acc = 0;
  int busy_cfg = 0, busy_at = -1, busy_big = 0;
  logic [15:0] lg_v [128];
  logic [7:0]  lg_d [128];
  logic [31:0] rs_v [64];
  int          rs_t [64];

  function automatic logic [7:0] rxval(input int k);
    return 8'((k * 37 + 5) & 255);
  endfunction
  function automatic logic [7:0] wbyte(input int v, input int k);
    return 8'((v * 16 + k * 7 + 1) & 255);
  endfunction

  assign bus_rdata = bus_sel ? {24'h0, m_dat}
                   : (m_ctl | 32'h20 | ((m_tb && m_left != 0) ? 32'h8 : 32'h0));

  always @(posedge clk) begin
    if (bus_we && !bus_sel) begin
      m_ctl <= bus_wdata & ~32'h8;
      if (bus_wdata[3]) begin
        m_tb <= 1'b1;
        m_left <= (n_l == busy_at) ? busy_big : busy_cfg;
        lg_v[n_l] <= bus_wdata[15:0]; lg_d[n_l] <= m_dat; n_l <= n_l + 1;
        if (bus_wdata[0]) begin rdmode <= m_dat[0]; m_rx <= 1'b0; end
        else m_rx <= rdmode;
      end else begin
        m_tb <= 1'b0; rs_v[n_r] <= bus_wdata; rs_t[n_r] <= cyc; n_r <= n_r + 1;
      end
    end
    if (bus_we && bus_sel) m_dat <= bus_wdata[7:0];
    if (bus_re && !bus_sel && m_tb) begin
      if (m_left == 0) begin
        m_tb <= 1'b0;
        if (m_rx) begin m_dat <= rxval(rxk); rxk <= rxk + 1; end
      end else m_left <= m_left - 1;
    end
    if (bus_we || bus_re) acc <= acc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic issue(input bit rd, input [6:0] a, input [7:0] r, input int len);
    @(negedge clk);
    req_valid = 1; req_rd = rd; req_addr = a; req_reg = r; req_len = 5'(len);
    @(negedge clk);
    req_valid = 0;
  endtask

  // rd, addr, reg, len, busy polls per byte, stream stall
  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 7'h41, 8'h10, 3'd0, 5'd1,  8'd2, 4'd0, 4'd0},
    {1'b0, 7'h7F, 8'hFF, 3'd0, 5'd3,  8'd1, 4'd0, 4'd2},
    {1'b1, 7'h12, 8'h05, 3'd0, 5'd1,  8'd3, 4'd0, 4'd0},
    {1'b1, 7'h55, 8'hA0, 3'd0, 5'd4,  8'd0, 4'd0, 4'd3},
    {1'b0, 7'h00, 8'h00, 3'd0, 5'd16, 8'd0, 4'd0, 4'd0},
    {1'b1, 7'h2A, 8'h33, 3'd0, 5'd16, 8'd1, 4'd0, 4'd1}
  };

  task automatic run(input int v, input bit rd, input [6:0] a, input [7:0] r,
                     input int len, input int busy, input int big, input int stall);
    int l0, r0, x0, nexp, bad_f, bad_d, bad_h;
    string stag;
    l0 = n_l; r0 = n_r; x0 = rxk; bad_h = 0;
    busy_cfg = busy; busy_big = big; busy_at = (big >= 0) ? n_l : -1;
    issue(rd, a, r, len);
    chk(!req_ready, "R9 req_ready low while busy", req_ready, 0);
    fork
      begin
        if (!rd) for (int k = 0; k < len; k++) begin
          repeat (stall) @(negedge clk);
          wd_valid = 1; wd_data = wbyte(v, k);
          while (!wd_ready) @(negedge clk);
          @(negedge clk); wd_valid = 0;
        end
      end
      begin
        if (rd) for (int k = 0; k < len; k++) begin
          logic [7:0] d0;
          while (!rd_valid) @(negedge clk);
          d0 = rd_data;
          for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            if (!rd_valid || rd_data != d0) bad_h++;
          end
          chk(rd_data == rxval(x0 + k), "R5 read byte order", rd_data, rxval(x0 + k));
          rd_ready = 1; @(negedge clk); rd_ready = 0;
        end
      end
      begin
        while (!done) @(negedge clk);
      end
    join
    chk(err == 0, "R9 err low on success", err, 0);
    @(negedge clk);
    chk(done == 0, "R9 done single cycle", done, 0);
    if (stall > 0 && rd) chk(bad_h == 0, "R5 read byte held under backpressure", bad_h, 0);
    chk(n_r - r0 == 3 && rs_v[r0] == 0 && rs_v[r0+1] == 32'h400 && rs_v[r0+2] == 32'h6000,
        "R1 reset write sequence", rs_v[r0+1], 32'h400);
    chk(rs_t[r0+1] - rs_t[r0] >= 500 && rs_t[r0+2] - rs_t[r0+1] >= 500,
        "R1 reset spacing", rs_t[r0+1] - rs_t[r0], 500);
    nexp = rd ? len + 3 : len + 2;
    stag = rd ? "R3 launch count" : "R2 launch count";
    chk(n_l - l0 == nexp, stag, n_l - l0, nexp);
    bad_f = 0; bad_d = 0;
    for (int j = 0; j < nexp && j < n_l - l0; j++) begin
      int fl, by;
      bit tx;
      tx = 1;
      if (j == 0) begin fl = 1; by = {a, 1'b0}; end
      else if (j == 1) begin fl = 0; by = r; end
      else if (rd && j == 2) begin fl = 1; by = {a, 1'b1}; end
      else if (rd) begin tx = 0; by = 0; fl = (j == len + 2) ? 6 : 0; end
      else begin by = wbyte(v, j - 2); fl = (j == len + 1) ? 2 : 0; end
      if (lg_v[l0+j][2:0] != 3'(fl)) bad_f++;
      if (lg_v[l0+j][15:3] != 13'h0C05) bad_f++;
      if (tx && lg_d[l0+j] != 8'(by)) bad_d++;
    end
    stag = rd ? "R3 launch flags, R4 preserved bits" : "R2 launch flags, R4 preserved bits";
    chk(bad_f == 0, stag, bad_f, 0);
    chk(bad_d == 0, "R5 data register loaded before launch", bad_d, 0);
    if (len == 16) chk(n_l - l0 == nexp, "R10 maximum length", n_l - l0, nexp);
  endtask

  task automatic err_case(input int len, input int big, input string tag);
    int l0, a0;
    l0 = n_l; a0 = acc;
    busy_cfg = 0; busy_big = big; busy_at = (big >= 0) ? n_l : -1;
    issue(1'b0, 7'h3C, 8'h44, len);
    while (!done) @(negedge clk);
    chk(err == 1, tag, err, 1);
    if (big < 0) chk(acc == a0, "R8 no bus access", acc - a0, 0);
    else chk(n_l - l0 == 1, "R7 no launch after timeout", n_l - l0, 1);
    a0 = acc;
    repeat (20) @(negedge clk);
    chk(acc == a0, "R7 bus quiet after error", acc - a0, 0);
    chk(req_ready == 1, "R9 back to idle", req_ready, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !done && !bus_we && !bus_re && !wd_ready && !rd_valid,
        "R9 reset state", {req_ready, done, bus_we, bus_re, wd_ready, rd_valid}, 6'b100000);
    for (int v = 0; v < NV; v++)
      run(v, VEC[v][39], VEC[v][38:32], VEC[v][31:24], int'(VEC[v][20:16]),
          int'(VEC[v][15:8]), -1, int'(VEC[v][3:0]));
    err_case(0, -1, "R8 zero length rejected");
    err_case(17, -1, "R8 over-long request rejected");
    run(6, 1'b0, 7'h19, 8'h77, 1, 0, 999, 0);
    chk(1'b1, "R6 cleared on final poll", 0, 0);
    err_case(1, 1000, "R7 timeout error");
    summary();
    $finish;
  end
endmodule